// File: doc/BRIEF.md
# AC Line Period and Zero-Crossing Detector

This block watches a stream of rectified line-voltage samples from an ADC. From these samples it finds the valleys of the rectified waveform and measures the time between them, in samples. It emits a one-cycle pulse at each line zero crossing. It also keeps a running mean of the line over each half cycle. Downstream timing, such as per-half-cycle averaging, RMS blocks and filter switching, uses the pulse as its half-cycle boundary and the half-period as its window length.

The crossing threshold is fixed at the start and adaptive later. For the first `INIT_LEN` accepted samples it is a programmed 7-bit level. After that it is the half-cycle mean that the block computes itself. The zero crossing is placed at the middle of each valley, between the sample that fell below the threshold and the sample that climbed back above it. A measured spacing outside the programmed window is replaced by the maximum allowed value, and a fault flag is raised. When the line disappears, timeout pulses keep the downstream timing alive. A separate early-warning flag reports a line that stays low for too long. It only signals and has no other effect.

All time is counted in accepted samples, so idle cycles between samples do not advance any counter. The sample input is a valid/ready stream. `in_ready` rises one clock after reset is released and then stays high, so there is never back-pressure. A sample is taken on every clock edge where `in_valid` and `in_ready` are both high.

Top module: `line_zc_timer`

## Requirements
- R1: `in_ready` is high from the first clock after reset release. Every sample with `in_valid` high is accepted. Cycles without a sample advance no timing, and `zc_pulse` is high only in the clock that follows an accepted sample.
- R2: During the first `INIT_LEN` accepted samples, the threshold is `thr_init` scaled by 2^(DW-7). From then on, the threshold is the value on `avg_level`. A sample is "low" when it is strictly below the threshold. A falling crossing is a low sample whose predecessor was not low.
- R3: At each falling crossing, `half_period` takes the number of samples since the previous falling crossing (the index difference). Reset counts as a crossing at index -1. The new value appears in the clock after that sample.
- R4: If the measured spacing is below `min_half` or above `max_half`, then `half_period` takes `max_half` and `period_fault` is 1. A plausible measurement clears `period_fault`. The limits are inclusive.
- R5: Let the falling crossing be at index f and the next non-low sample at index r, giving width W = r - f. Then `zc_pulse` is high for exactly one clock after the sample at index r + floor(W/2). When W is 1, the pulse follows r itself.
- R6: If the sample that arrives `max_half`+1 samples after the last falling crossing or timeout is not itself a falling crossing, that sample raises `zc_pulse`. It also sets `half_period` to `max_half` and `period_fault` to 1. From reset, the first timeout is at sample index `max_half`.
- R7: At each `zc_pulse` event, real or from a timeout, the floor of the mean of the samples accepted since the previous event is computed. The window excludes the previous event's sample and includes the current one. The result appears on `avg_level` within DW+CNT_W+3 clocks, provided the previous division is already finished.
- R8: `line_low` goes high on the sample at which the run of consecutive samples below `low_level` exceeds a limit. The limit is chosen by `warn_sel`: 0 gives floor(`half_period`/2), 1 gives `half_period`, 2 gives `WARN_A` and 3 gives `WARN_B`. The flag clears on the first sample at or above `low_level`, and it changes no other output.
- R9: After reset, `half_period`, `zc_pulse`, `period_fault`, `avg_level` and `line_low` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| in_valid | input | 1 | sample strobe |
| in_ready | output | 1 | block can accept a sample (high after reset) |
| in_sample | input | DW | rectified line-voltage sample |
| thr_init | input | 7 | starting crossing threshold, top bits of a sample |
| min_half | input | CNT_W | smallest plausible half period, in samples |
| max_half | input | CNT_W | largest plausible half period, also the timeout |
| low_level | input | DW | line-low warning level |
| warn_sel | input | 2 | line-low time limit select |
| half_period | output | CNT_W | last half-period value |
| zc_pulse | output | 1 | one-clock zero-crossing pulse |
| period_fault | output | 1 | last half-period was implausible or timed out |
| avg_level | output | DW | last half-cycle mean, the adaptive threshold |
| line_low | output | 1 | line stayed low beyond the selected limit |

## Verification
Suppose the valley-width or countdown state is wrong. The zero-crossing pulse then moves away from index k·H + floor(V/2) on the very next valley, and a per-sample comparison reveals it. Suppose instead the period counter is off. The `half_period` value then differs by a sample at the next falling crossing, or a spurious timeout pulse appears, at the latest `max_half` samples later. A defect in the accumulator or divider shows up as a wrong `avg_level` about thirty clocks after a complete half cycle. The consecutive-low counter is compared on every sample in steady state, so an off-by-one in the warning limit shows up on the first valley that reaches it.

// File: rtl/line_zc_pkg.sv
package line_zc_pkg;
  typedef enum logic [1:0] {
    WARN_QUARTER = 2'd0,
    WARN_HALF    = 2'd1,
    WARN_SHORT   = 2'd2,
    WARN_LONG    = 2'd3
  } warn_sel_e;
endpackage

// File: rtl/lzc_cross.sv
// Threshold select, crossing detection and valley-midpoint countdown.
module lzc_cross #(
  parameter int DW       = 11,
  parameter int CNT_W    = 16,
  parameter int INIT_LEN = 4000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic [DW-1:0]    sample,
  input  logic [6:0]       thr_init,
  input  logic [DW-1:0]    avg_level,
  output logic             fall_now,
  output logic             zc_now
);
  localparam int INIT_W = $clog2(INIT_LEN + 1);
  localparam int SH     = DW - 7;

  logic [INIT_W-1:0] init_cnt;
  logic              prev_low, valley_act, down_act;
  logic [CNT_W-1:0]  vwidth, down;
  logic [DW-1:0]     thr;
  logic              init_phase, is_low, rise_now;
  logic [CNT_W-1:0]  half_w;

  assign init_phase = init_cnt < INIT_W'(INIT_LEN);
  assign thr        = init_phase ? (DW'(thr_init) << SH) : avg_level;
  assign is_low     = sample < thr;
  assign fall_now   = acc && is_low && !prev_low;
  assign rise_now   = acc && !is_low && valley_act;
  assign half_w     = vwidth >> 1;
  assign zc_now     = (rise_now && half_w == '0) ||
                      (acc && down_act && down == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_cnt   <= '0;
      prev_low   <= 1'b1;
      valley_act <= 1'b0;
      vwidth     <= '0;
      down_act   <= 1'b0;
      down       <= '0;
    end else if (acc) begin
      if (init_phase) init_cnt <= init_cnt + 1'b1;
      prev_low <= is_low;
      if (fall_now) begin
        valley_act <= 1'b1;
        vwidth     <= CNT_W'(1);
      end else if (valley_act && is_low && vwidth != '1) begin
        vwidth <= vwidth + 1'b1;
      end
      if (rise_now) begin
        valley_act <= 1'b0;
        down_act   <= half_w != '0;
        down       <= half_w;
      end else if (down_act) begin
        if (down == CNT_W'(1)) down_act <= 1'b0;
        else down <= down - 1'b1;
      end
    end
  end
endmodule

// File: rtl/lzc_period.sv
// Half-period measurement, plausibility window and timeout.
module lzc_period #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic             fall_now,
  input  logic [CNT_W-1:0] min_half,
  input  logic [CNT_W-1:0] max_half,
  output logic [CNT_W-1:0] half_period,
  output logic             period_fault,
  output logic             tmo_now
);
  logic [CNT_W-1:0] pc;
  logic [CNT_W:0]   meas;
  logic             bad, upd;

  assign meas    = {1'b0, pc} + 1'b1;
  assign bad     = (meas < {1'b0, min_half}) || (meas > {1'b0, max_half});
  assign tmo_now = acc && !fall_now && (pc >= max_half);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc           <= '0;
      half_period  <= '0;
      period_fault <= 1'b0;
      upd          <= 1'b0;
    end else begin
      upd <= 1'b0;
      if (acc) begin
        if (fall_now) begin
          pc           <= '0;
          half_period  <= bad ? max_half : meas[CNT_W-1:0];
          period_fault <= bad;
          upd          <= 1'b1;
        end else if (tmo_now) begin
          pc           <= '0;
          half_period  <= max_half;
          period_fault <= 1'b1;
          upd          <= 1'b1;
        end else begin
          pc <= pc + 1'b1;
        end
      end
    end
  end

  // R6
  pc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc) |-> pc <= $past(max_half));

  // R4
  fault_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && period_fault) |-> half_period == $past(max_half));
endmodule

// File: rtl/lzc_avg.sv
// Half-cycle accumulator with a restoring sequential divider.
module lzc_avg #(
  parameter int DW    = 11,
  parameter int CNT_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic [DW-1:0] sample,
  input  logic          zc_now,
  output logic [DW-1:0] avg_level
);
  localparam int ACC_W  = DW + CNT_W + 1;
  localparam int DEN_W  = CNT_W + 1;
  localparam int STEP_W = $clog2(ACC_W + 1);
  localparam int PW     = ACC_W + DEN_W;

  logic [ACC_W-1:0]  sum, nq, num_q;
  logic [DEN_W-1:0]  cnt, den_q, rem;
  logic [DEN_W:0]    rem_sh;
  logic [STEP_W-1:0] step;
  logic              busy, fin, ge;
  logic [ACC_W-1:0]  num_in;
  logic [DEN_W-1:0]  den_in;

  assign num_in = sum + ACC_W'(sample);
  assign den_in = cnt + 1'b1;
  assign rem_sh = {rem, nq[ACC_W-1]};
  assign ge     = rem_sh >= {1'b0, den_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum <= '0; cnt <= '0; nq <= '0; num_q <= '0; den_q <= '0;
      rem <= '0; step <= '0; busy <= 1'b0; fin <= 1'b0;
      avg_level <= '0;
    end else begin
      fin <= 1'b0;
      if (acc) begin
        if (zc_now) begin
          sum <= '0;
          cnt <= '0;
        end else begin
          sum <= num_in;
          cnt <= den_in;
        end
      end
      if (busy) begin
        nq   <= {nq[ACC_W-2:0], ge};
        rem  <= ge ? DEN_W'(rem_sh - {1'b0, den_q}) : rem_sh[DEN_W-1:0];
        step <= step + 1'b1;
        if (step == STEP_W'(ACC_W - 1)) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end else if (acc && zc_now) begin
        busy  <= 1'b1;
        step  <= '0;
        nq    <= num_in;
        num_q <= num_in;
        den_q <= den_in;
        rem   <= '0;
      end
      if (fin) avg_level <= nq[DW-1:0];
    end
  end

  // R7
  div_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> ((PW'(nq) * PW'(den_q) <= PW'(num_q)) &&
             (PW'(num_q) - PW'(nq) * PW'(den_q) < PW'(den_q))));
endmodule

// File: rtl/lzc_lowwarn.sv
// Consecutive-low counter and line-low warning.
module lzc_lowwarn
  import line_zc_pkg::*;
#(
  parameter int DW     = 11,
  parameter int CNT_W  = 16,
  parameter int WARN_A = 200,
  parameter int WARN_B = 400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic [DW-1:0]    sample,
  input  logic [DW-1:0]    low_level,
  input  logic [1:0]       warn_sel,
  input  logic [CNT_W-1:0] half_period,
  output logic             line_low
);
  localparam int LW = CNT_W + 1;

  warn_sel_e      sel;
  logic [LW-1:0]  limit, run, run_n;

  assign sel = warn_sel_e'(warn_sel);

  always_comb begin
    unique case (sel)
      WARN_QUARTER: limit = LW'(half_period >> 1);
      WARN_HALF:    limit = LW'(half_period);
      WARN_SHORT:   limit = LW'(WARN_A);
      default:      limit = LW'(WARN_B);
    endcase
  end

  assign run_n = (run == '1) ? run : run + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run      <= '0;
      line_low <= 1'b0;
    end else if (acc) begin
      if (sample < low_level) begin
        run      <= run_n;
        line_low <= run_n > limit;
      end else begin
        run      <= '0;
        line_low <= 1'b0;
      end
    end
  end

  // R8
  warn_on_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_low) |-> $past(acc));
endmodule

// File: rtl/line_zc_timer.sv
module line_zc_timer #(
  parameter int DW       = 11,
  parameter int CNT_W    = 16,
  parameter int INIT_LEN = 4000,
  parameter int WARN_A   = 200,
  parameter int WARN_B   = 400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DW-1:0]    in_sample,
  input  logic [6:0]       thr_init,
  input  logic [CNT_W-1:0] min_half,
  input  logic [CNT_W-1:0] max_half,
  input  logic [DW-1:0]    low_level,
  input  logic [1:0]       warn_sel,
  output logic [CNT_W-1:0] half_period,
  output logic             zc_pulse,
  output logic             period_fault,
  output logic [DW-1:0]    avg_level,
  output logic             line_low
);
  logic acc, fall_now, zc_real, tmo_now, zc_any;

  assign acc    = in_valid && in_ready;
  assign zc_any = zc_real || tmo_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_ready <= 1'b0;
      zc_pulse <= 1'b0;
    end else begin
      in_ready <= 1'b1;
      zc_pulse <= acc && zc_any;
    end
  end

  lzc_cross #(.DW(DW), .CNT_W(CNT_W), .INIT_LEN(INIT_LEN)) u_cross (
    .clk(clk), .rst_n(rst_n), .acc(acc), .sample(in_sample),
    .thr_init(thr_init), .avg_level(avg_level),
    .fall_now(fall_now), .zc_now(zc_real));

  lzc_period #(.CNT_W(CNT_W)) u_period (
    .clk(clk), .rst_n(rst_n), .acc(acc), .fall_now(fall_now),
    .min_half(min_half), .max_half(max_half),
    .half_period(half_period), .period_fault(period_fault),
    .tmo_now(tmo_now));

  lzc_avg #(.DW(DW), .CNT_W(CNT_W)) u_avg (
    .clk(clk), .rst_n(rst_n), .acc(acc), .sample(in_sample),
    .zc_now(zc_any), .avg_level(avg_level));

  lzc_lowwarn #(.DW(DW), .CNT_W(CNT_W), .WARN_A(WARN_A), .WARN_B(WARN_B)) u_warn (
    .clk(clk), .rst_n(rst_n), .acc(acc), .sample(in_sample),
    .low_level(low_level), .warn_sel(warn_sel),
    .half_period(half_period), .line_low(line_low));

  // R1
  zc_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zc_pulse |-> $past(acc));
endmodule

// File: tb/line_zc_timer_tb.sv
module line_zc_timer_tb;
  localparam int DW = 11, CNT_W = 12, INIT_LEN = 64, WA = 5, WB = 9;
  localparam int LO = 100, HI = 1500, LOWLVL = 300;

  logic clk = 0, rst_n = 0, in_valid = 0, in_ready;
  logic [DW-1:0] in_sample = '0, low_level = DW'(LOWLVL);
  logic [6:0] thr_init = 7'd40;
  logic [CNT_W-1:0] min_half = '0, max_half = '0;
  logic [1:0] warn_sel = 2'd0;
  logic [CNT_W-1:0] half_period;
  logic zc_pulse, period_fault, line_low;
  logic [DW-1:0] avg_level;

  int checks = 0, fails = 0, cyc = 0;

  line_zc_timer #(.DW(DW), .CNT_W(CNT_W), .INIT_LEN(INIT_LEN), .WARN_A(WA), .WARN_B(WB)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .thr_init(thr_init), .min_half(min_half),
    .max_half(max_half), .low_level(low_level), .warn_sel(warn_sel),
    .half_period(half_period), .zc_pulse(zc_pulse), .period_fault(period_fault),
    .avg_level(avg_level), .line_low(line_low));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog expired: act=%0d exp<=150000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; in_valid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  // One configuration: H samples per half cycle, V of them in the valley.
  task automatic run_cfg(input int h, input int v, input int mn, input int mx,
                         input int sel, input int gap, input bit thr0);
    int run = 0;
    int lim;
    bit bad;
    int exp_half, exp_avg;
    bad = (h < mn) || (h > mx);
    exp_half = bad ? mx : h;
    case (sel)
      0: lim = exp_half / 2;
      1: lim = exp_half;
      2: lim = WA;
      default: lim = WB;
    endcase
    min_half = CNT_W'(mn); max_half = CNT_W'(mx);
    warn_sel = 2'(sel); thr_init = thr0 ? 7'd0 : 7'd40;
    do_reset();
    // R9 reset state, R1 ready
    chk(in_ready == 1'b1, "R1 ready", int'(in_ready), 1);
    chk(half_period == '0 && !period_fault && !zc_pulse && avg_level == '0 && !line_low,
        "R9 reset", int'(half_period) + int'(avg_level), 0);
    for (int i = 0; i < 8 * h; i++) begin
      bit low, ezc, chk_zc;
      low = (i % h) >= (h - v);
      in_valid = 1; in_sample = low ? DW'(LO) : DW'(HI);
      @(negedge clk);
      in_valid = 0;
      run = (low && LO < LOWLVL) ? run + 1 : 0;
      chk_zc = 1;
      if (thr0) begin
        if (i < INIT_LEN) ezc = (i % (mx + 1)) == mx;   // R2 R6 init threshold never crossed
        else if (i >= 5 * h) ezc = (i >= h) && ((i % h) == v / 2);
        else chk_zc = 0;
      end else begin
        ezc = (i >= h) && ((i % h) == v / 2);           // R5 R2 R3
      end
      if (chk_zc) chk(zc_pulse == ezc, "R5 zc position", int'(zc_pulse), int'(ezc));
      if (i >= 5 * h)
        chk(line_low == (run > lim), "R8 line_low", int'(line_low), int'(run > lim));
      for (int g = 0; g < (gap ? i % 3 : 0); g++) begin
        @(negedge clk);
        chk(zc_pulse == 1'b0, "R1 idle no pulse", int'(zc_pulse), 0);
      end
    end
    repeat (40) @(negedge clk);
    chk(int'(half_period) == exp_half, "R3 R4 half_period", int'(half_period), exp_half);
    chk(period_fault == bad, "R4 period_fault", int'(period_fault), int'(bad));
    exp_avg = (v * LO + (h - v) * HI) / h;
    chk(int'(avg_level) == exp_avg, "R7 avg_level", int'(avg_level), exp_avg);
  endtask

  initial begin
    run_cfg(20, 6, 10, 40, 2, 0, 0);
    run_cfg(24, 9, 24, 24, 3, 0, 0);  // R4 limits inclusive
    run_cfg(30, 17, 10, 60, 0, 1, 0); // R1 gaps, R8 quarter limit
    run_cfg(20, 4, 10, 40, 1, 0, 0);
    run_cfg(22, 1, 10, 40, 2, 0, 0);  // R5 width one
    run_cfg(20, 6, 21, 40, 2, 0, 0);  // R4 below min
    run_cfg(20, 6, 5, 19, 2, 0, 0);   // R4 one above max
    run_cfg(20, 6, 5, 30, 2, 0, 1);   // R6 timeout pulses during init
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule